// File: doc/BRIEF.md
# Sixteen-Operation ALU with Carry and Zero Flags

This block is a purely combinational arithmetic-logic unit for 8-bit unsigned operands. A 4-bit operation code selects one of sixteen functions: add, subtract, increment, decrement, full-width multiply, divide, six bitwise functions, one-place logical shifts, and one-place rotates. The result bus is twice the operand width, so the whole multiplication product fits. Every other function places its answer in the low half and clears the high half.

Two flags go with each result. Carry reports the ninth bit of an addition, or the bit pushed out of the top on a left shift, and is low for every other function. Zero reports that the whole result is zero. Division by zero does not leave the output undefined: it gives an all-ones low byte. The block has no registers and no handshake. It sits between a producer that holds its operands steady and a consumer that samples the outputs once the logic has settled. The stream-style valid/ready interface does not apply because the block has no state, so back-pressure does not arise.

Top module: `opsel_alu`

## Requirements
- R1: The operation code maps as follows: 0x0 add, 0x1 subtract, 0x2 increment, 0x3 decrement, 0x4 multiply, 0x5 divide, 0x6 AND, 0x7 OR, 0x8 XOR, 0x9 NAND, 0xA NOR, 0xB XNOR, 0xC shift left, 0xD shift right, 0xE rotate right, 0xF rotate left.
- R2: Add gives (a+b) mod 256 in the low byte, with carry equal to bit 8 of the 9-bit sum.
- R3: Subtract gives (a-b) mod 256. Increment gives (a+1) mod 256 and decrement gives (a-1) mod 256, both wrapping.
- R4: Multiply gives the full 16-bit unsigned product a*b across the whole result.
- R5: Divide gives the unsigned quotient a/b in the low byte. When b is zero the result is 0x00FF.
- R6: The bitwise codes give a&b, a|b, a^b, ~(a&b), ~(a|b) and ~(a^b) in the low byte.
- R7: Shift left gives a shifted up one place with bit 0 filled with 0, and carry equal to the old bit 7 of a.
- R8: Shift right is logical (bit 7 filled with 0). Rotate right moves bit 0 of a into bit 7. Rotate left moves bit 7 of a into bit 0.
- R9: For every code except multiply, the high byte of the result is 0x00.
- R10: Carry is 0 for every code other than add and shift left, including subtract.
- R11: Zero is 1 exactly when all 16 result bits are 0.
- R12: Increment, decrement, shifts and rotates depend only on a: changing b leaves all three outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| opnd_a | input | 8 | First operand, and the only operand of unary codes |
| opnd_b | input | 8 | Second operand |
| result | output | 16 | Result; the high byte is used only by multiply |
| carry | output | 1 | Carry-out of add, or the bit shifted out on shift left |
| zero | output | 1 | High when the result is all zero |

## Verification
Every output is due zero clock cycles after a stimulus, because there is no register anywhere between the operand pins and the flags. The bench applies each operand set just after a rising edge and queues its expected value. The monitor compares on the falling edge of the same cycle, half a period later, when all the logic has settled. Because of this, each queued item is checked against exactly the stimulus that produced it, with no skew from the order of processes at the edge.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_INC  = 4'h2,
    OP_DEC  = 4'h3,
    OP_MUL  = 4'h4,
    OP_DIV  = 4'h5,
    OP_AND  = 4'h6,
    OP_OR   = 4'h7,
    OP_XOR  = 4'h8,
    OP_NAND = 4'h9,
    OP_NOR  = 4'hA,
    OP_XNOR = 4'hB,
    OP_SHL  = 4'hC,
    OP_SHR  = 4'hD,
    OP_ROR  = 4'hE,
    OP_ROL  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_SHIFT = 2'd2
  } op_class_e;

  function automatic op_class_e classify(input alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_MUL, OP_DIV: classify = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR: classify = CLS_LOGIC;
      default: classify = CLS_SHIFT;
    endcase
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] res,
  output logic           cout
);
  localparam int RW = 2 * W;

  logic [W:0]    sum_ext;
  logic [W-1:0]  diff;
  logic [W-1:0]  incr;
  logic [W-1:0]  decr;
  logic [RW-1:0] prod;
  logic [W-1:0]  quot;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    diff    = a - b;
    incr    = a + {{(W-1){1'b0}}, 1'b1};
    decr    = a - {{(W-1){1'b0}}, 1'b1};
    prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    quot    = (b == '0) ? {W{1'b1}} : (a / b);
  end

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_ADD: begin
        res  = {{W{1'b0}}, sum_ext[W-1:0]};
        cout = sum_ext[W];
      end
      OP_SUB:  res = {{W{1'b0}}, diff};
      OP_INC:  res = {{W{1'b0}}, incr};
      OP_DEC:  res = {{W{1'b0}}, decr};
      OP_MUL:  res = prod;
      OP_DIV:  res = {{W{1'b0}}, quot};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  logic [W-1:0] base;
  logic         invert;

  always_comb begin
    invert = 1'b0;
    case (op)
      OP_AND:  base = a & b;
      OP_OR:   base = a | b;
      OP_XOR:  base = a ^ b;
      OP_NAND: begin base = a & b; invert = 1'b1; end
      OP_NOR:  begin base = a | b; invert = 1'b1; end
      OP_XNOR: begin base = a ^ b; invert = 1'b1; end
      default: base = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign res[i] = base[i] ^ invert;
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W-1:0] up_fill0;
  logic [W-1:0] dn_fill0;
  logic [W-1:0] rot_up;
  logic [W-1:0] rot_dn;

  for (genvar i = 0; i < W; i++) begin : g_bits
    if (i == 0) begin : g_lsb
      assign up_fill0[i] = 1'b0;
      assign rot_up[i]   = a[W-1];
    end else begin : g_up
      assign up_fill0[i] = a[i-1];
      assign rot_up[i]   = a[i-1];
    end
    if (i == W-1) begin : g_msb
      assign dn_fill0[i] = 1'b0;
      assign rot_dn[i]   = a[0];
    end else begin : g_dn
      assign dn_fill0[i] = a[i+1];
      assign rot_dn[i]   = a[i+1];
    end
  end

  always_comb begin
    cout = 1'b0;
    case (op)
      OP_SHL: begin
        res  = up_fill0;
        cout = a[W-1];
      end
      OP_SHR:  res = dn_fill0;
      OP_ROR:  res = rot_dn;
      OP_ROL:  res = rot_up;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]     op_sel,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  output logic [2*W-1:0] result,
  output logic           carry,
  output logic           zero
);
  localparam int RW = 2 * W;

  alu_op_e       op;
  op_class_e     cls;
  logic [RW-1:0] arith_res;
  logic          arith_c;
  logic [W-1:0]  logic_res;
  logic [W-1:0]  shift_res;
  logic          shift_c;

  assign op  = alu_op_e'(op_sel);
  assign cls = classify(op);

  alu_arith #(.W(W)) u_arith (
    .op(op), .a(opnd_a), .b(opnd_b), .res(arith_res), .cout(arith_c)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .res(logic_res)
  );

  alu_shift #(.W(W)) u_shift (
    .op(op), .a(opnd_a), .res(shift_res), .cout(shift_c)
  );

  always_comb begin
    case (cls)
      CLS_ARITH: begin result = arith_res;                carry = arith_c; end
      CLS_LOGIC: begin result = {{W{1'b0}}, logic_res};   carry = 1'b0;    end
      default:   begin result = {{W{1'b0}}, shift_res};   carry = shift_c; end
    endcase
    zero = ~|result;
  end
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
  parameter int W = 8
) (
  input logic [3:0]     op_sel,
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic [2*W-1:0] result,
  input logic           carry,
  input logic           zero
);
  logic [W:0]     sum9;
  logic [2*W-1:0] full_prod;

  always_comb begin
    sum9      = {1'b0, opnd_a} + {1'b0, opnd_b};
    full_prod = {{W{1'b0}}, opnd_a} * {{W{1'b0}}, opnd_b};

    // R2
    add_carry_chk: assert (op_sel != 4'h0 || {carry, result[W-1:0]} == sum9)
      else $error("add result/carry mismatch");
    // R4
    mul_full_chk: assert (op_sel != 4'h4 || result == full_prod)
      else $error("multiply product mismatch");
    // R5
    div_zero_chk: assert (!(op_sel == 4'h5 && opnd_b == '0) || result == {{W{1'b0}}, {W{1'b1}}})
      else $error("divide by zero not all ones");
    // R7
    shl_out_chk: assert (op_sel != 4'hC || (carry == opnd_a[W-1] && !result[0]))
      else $error("shift left carry/fill wrong");
    // R9
    hi_byte_chk: assert (op_sel == 4'h4 || result[2*W-1:W] == '0)
      else $error("high byte not clear");
    // R10
    carry_scope_chk: assert (op_sel == 4'h0 || op_sel == 4'hC || !carry)
      else $error("carry set on wrong code");
    // R11
    equal_zero_chk: assert (!(op_sel == 4'h1 || op_sel == 4'h8) || zero == (opnd_a == opnd_b))
      else $error("zero flag wrong on equal operands");
  end
endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) u_chk (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .result(result), .carry(carry), .zero(zero)
);

// File: tb/opsel_alu_bench.sv
module opsel_alu_bench;
  localparam int W = 8;

  typedef struct {
    logic [3:0]   op;
    logic [7:0]   a;
    logic [7:0]   b;
    logic [15:0]  res;
    logic         c;
    logic         z;
    string        tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [7:0]  opnd_a = '0;
  logic [7:0]  opnd_b = '0;
  logic [15:0] result;
  logic        carry;
  logic        zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  opsel_alu #(.W(W)) u_opsel_alu (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .carry(carry), .zero(zero)
  );

  function automatic item_t model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input string tag);
    item_t it;
    logic [8:0] s;
    logic [7:0] lo;
    it.op = op; it.a = a; it.b = b; it.tag = tag;
    it.c = 1'b0;
    lo = 8'h00;
    it.res = 16'h0000;
    case (op)
      4'h0: begin s = a + b; lo = s[7:0]; it.c = s[8]; end
      4'h1: lo = a - b;
      4'h2: lo = a + 8'd1;
      4'h3: lo = a - 8'd1;
      4'h5: lo = (b == 0) ? 8'hFF : a / b;
      4'h6: lo = a & b;
      4'h7: lo = a | b;
      4'h8: lo = a ^ b;
      4'h9: lo = ~(a & b);
      4'hA: lo = ~(a | b);
      4'hB: lo = ~(a ^ b);
      4'hC: begin lo = {a[6:0], 1'b0}; it.c = a[7]; end
      4'hD: lo = {1'b0, a[7:1]};
      4'hE: lo = {a[0], a[7:1]};
      4'hF: lo = {a[6:0], a[7]};
      default: lo = 8'h00;
    endcase
    if (op == 4'h4) it.res = 16'(a) * 16'(b);
    else            it.res = {8'h00, lo};
    it.z = (it.res == 16'h0000);
    return it;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input string tag);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    sb_q.push_back(model(op, a, b, tag));
  endtask

  // Monitor: results are combinational, due in the same cycle; compare at negedge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        checks++;
        if (result !== e.res || carry !== e.c || zero !== e.z) begin
          fails++;
          $display("FAIL %s op=%h a=%h b=%h actual res=%h c=%b z=%b expected res=%h c=%b z=%b",
                   e.tag, e.op, e.a, e.b, result, carry, zero, e.res, e.c, e.z);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state style check: all-zero inputs on add.
    drive(4'h0, 8'h00, 8'h00, "R11 idle");
    // R1: full opcode sweep on 0xEE, 0xEE.
    for (int k = 0; k < 16; k++) drive(4'(k), 8'hEE, 8'hEE, "R1 sweep");
    // R2: add wrap to zero sets carry and zero.
    drive(4'h0, 8'hFF, 8'h01, "R2 wrap");
    drive(4'h0, 8'h12, 8'h34, "R2 plain");
    // R3: subtract underflow, increment/decrement wrap.
    drive(4'h1, 8'h03, 8'h05, "R3 sub under");
    drive(4'h2, 8'hFF, 8'h00, "R3 inc wrap");
    drive(4'h3, 8'h00, 8'h00, "R3 dec wrap");
    // R4: multiply extremes.
    drive(4'h4, 8'hFF, 8'hFF, "R4 max");
    drive(4'h4, 8'h00, 8'h9C, "R4 zero");
    // R5: divide with remainder and by zero.
    drive(4'h5, 8'hC8, 8'h07, "R5 quot");
    drive(4'h5, 8'h42, 8'h00, "R5 by zero");
    // R6: bitwise on mixed pattern.
    for (int k = 6; k < 12; k++) drive(4'(k), 8'hA5, 8'h3C, "R6 bitwise");
    // R7: shift-left carry out and zero.
    drive(4'hC, 8'h80, 8'h00, "R7 msb out");
    drive(4'hC, 8'h41, 8'hFF, "R7 no carry");
    // R8: logical right and rotates.
    drive(4'hD, 8'h81, 8'h00, "R8 shr");
    drive(4'hE, 8'h01, 8'h00, "R8 ror");
    drive(4'hF, 8'h80, 8'h00, "R8 rol");
    // R9 and R10: mixed patterns over all codes.
    for (int k = 0; k < 16; k++) drive(4'(k), 8'h9B, 8'h27, "R9 R10 mix");
    // R12: unary codes unaffected by b.
    for (int k = 2; k < 4; k++) begin
      drive(4'(k), 8'h5A, 8'h00, "R12 b0");
      drive(4'(k), 8'h5A, 8'hFF, "R12 bFF");
    end
    for (int k = 12; k < 16; k++) begin
      drive(4'(k), 8'hC3, 8'h00, "R12 b0");
      drive(4'(k), 8'hC3, 8'hFF, "R12 bFF");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule